// File: doc/BRIEF.md
# SPI Serial EEPROM Write Controller

This block is the slave-side control logic of a small serial EEPROM attached to a SPI bus in mode 0. It oversamples the serial clock, chip select and data-in lines in the system clock domain. It decodes one opcode byte per transaction and runs the write path. A write-enable transaction arms a latch. A later write transaction carries an opcode byte, an address byte and one or more data bytes. Those bytes are collected in a one-page buffer. When chip select rises cleanly on a byte boundary, a self-timed programming cycle copies the buffered bytes into a register-array memory. The write-in-progress flag and the write-enable latch can be read through a status byte at any time, including during programming. A plain read opcode streams bytes out of the array.

The serial side has no back-pressure. Every byte that arrives is consumed in the system clock cycle after its eighth bit. Every outgoing byte is prepared before the falling serial clock edge that starts it. Because of this, the internal byte stream between the shifter and the decoder carries only a valid strobe and has no ready signal. The serial clock must run at least ten times slower than the system clock.

Top module: `spi_eeprom_wctl`

## Requirements
- R1: After reset, the status byte reads {4'b0, BP_INIT, wel=0, wip=0}, with wip in bit 0, wel in bit 1 and the block-protect bits in bits 3:2. The data-out enable is low while chip select is high.
- R2: Opcode 0x06 (write enable) sets the write-enable latch, so status bit 1 reads 1. A status read uses opcode 0x05 and returns the status byte on every following byte slot.
- R3: A write (opcode 0x02) sent while the write-enable latch is clear is ignored. The array is unchanged and wip stays 0.
- R4: A write commits only when chip select rises right after a complete data byte. A rise after 1 to 7 bits of a byte cancels the write, nothing is programmed, and wip stays 0.
- R5: A write transaction that ends after the address byte, with no data byte, programs nothing.
- R6: The low 4 address bits count bytes within the 16-byte page and wrap from 15 to 0. The upper address bits never change. A later byte overwrites an earlier byte that landed on the same location.
- R7: At the end of programming, only the locations that received data are updated. Every other byte keeps its value.
- R8: wip reads 1 for PROG_CYCLES system clocks after a commit. When wip clears, wel also clears.
- R9: While wip is 1, the status read returns {BP_INIT, wel=1, wip=1}. Write enable, write and read opcodes are ignored.
- R10: Opcode 0x03 followed by an address byte returns array bytes MSB first, starting at that address. The address increments for each byte and wraps from the top of the array to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| spi_sck | input | 1 | Serial clock, idle low, sampled on rising edges |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in, MSB first |
| spi_miso | output | 1 | Serial data out, updated after falling serial clock edges |
| spi_miso_oe | output | 1 | High when spi_miso should be driven; the pad floats otherwise |

## Verification
The assertions assume that the serial lines obey mode 0 timing. Each serial clock half period must last several system clocks so that the synchronizers see every edge. Chip select may change only while the serial clock is low and must hold between edges. The bench drives every serial line from the falling system clock edge with a fixed half period of six system clocks. It raises chip select only after the last falling serial clock edge has settled. Random operation kinds, addresses, lengths and cut points come from a seeded generator and all stay within these rules.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_RDSR  = 8'h05;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPCODE,
    ST_WADDR,
    ST_WDATA,
    ST_RADDR,
    ST_RDATA,
    ST_STATUS,
    ST_IGNORE
  } cmd_state_t;
endpackage

// File: rtl/spi_eeprom_frontend.sv
module spi_eeprom_frontend #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       mosi,
  input  logic [7:0] tx_byte,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       sel_start,
  output logic       sel_end,
  output logic       sel_aligned,
  output logic       miso,
  output logic       miso_oe
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sck_q, cs_q, mosi_q;
  logic         sck_d, cs_d;
  logic [2:0]   bit_cnt;
  logic [7:0]   rx_sh;
  logic [7:0]   tx_sh;
  logic         sck_now, cs_now, mosi_now, sck_rise, sck_fall;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sck_q <= '0; cs_q <= '1; mosi_q <= '0;
        end else begin
          sck_q <= sck; cs_q <= cs_n; mosi_q <= mosi;
        end
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sck_q <= '0; cs_q <= '1; mosi_q <= '0;
        end else begin
          sck_q  <= {sck_q[TOP-1:0], sck};
          cs_q   <= {cs_q[TOP-1:0], cs_n};
          mosi_q <= {mosi_q[TOP-1:0], mosi};
        end
      end
    end
  endgenerate

  assign sck_now  = sck_q[TOP];
  assign cs_now   = cs_q[TOP];
  assign mosi_now = mosi_q[TOP];
  assign sck_rise = sck_now & ~sck_d & ~cs_now;
  assign sck_fall = ~sck_now & sck_d & ~cs_now;
  assign sel_start   = cs_d & ~cs_now;
  assign sel_end     = ~cs_d & cs_now;
  assign sel_aligned = (bit_cnt == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0; cs_d <= 1'b1;
    end else begin
      sck_d <= sck_now; cs_d <= cs_now;
    end
  end

  // receive shifter, one strobe per complete byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      rx_sh    <= '0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (cs_now) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        rx_sh   <= {rx_sh[6:0], mosi_now};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          rx_valid <= 1'b1;
          rx_byte  <= {rx_sh[6:0], mosi_now};
        end
      end
    end
  end

  // transmit shifter, loads a fresh byte on the falling edge after a boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
    end else begin
      miso_oe <= ~cs_now;
      if (sck_fall) begin
        if (bit_cnt == 3'd0) begin
          miso  <= tx_byte[7];
          tx_sh <= {tx_byte[6:0], 1'b0};
        end else begin
          miso  <= tx_sh[7];
          tx_sh <= {tx_sh[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_eeprom_array.sv
module spi_eeprom_array #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [ADDR_W-PAGE_W-1:0]              wr_page,
  input  logic [(1<<PAGE_W)-1:0]                wr_mask,
  input  logic [(1<<PAGE_W)-1:0][7:0]           wr_data,
  input  logic [ADDR_W-1:0]                     rd_addr,
  output logic [7:0]                            rd_data
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) mem[j] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (wr_mask[i]) mem[{wr_page, PAGE_W'(i)}] <= wr_data[i];
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/spi_eeprom_cmd.sv
module spi_eeprom_cmd
  import spi_eeprom_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         PAGE_W      = 4,
  parameter int         PROG_CYCLES = 1200,
  parameter logic [1:0] BP_INIT     = 2'b10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rx_valid,
  input  logic [7:0]                   rx_byte,
  input  logic                         sel_start,
  input  logic                         sel_end,
  input  logic                         sel_aligned,
  input  logic [7:0]                   rd_data,
  output logic [7:0]                   tx_byte,
  output logic [ADDR_W-1:0]            rd_addr,
  output logic                         wr_en,
  output logic [ADDR_W-PAGE_W-1:0]     wr_page,
  output logic [(1<<PAGE_W)-1:0]       wr_mask,
  output logic [(1<<PAGE_W)-1:0][7:0]  wr_data,
  output logic                         wip,
  output logic                         wel
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int CNT_W      = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PROG_CYCLES - 1);

  cmd_state_t                     state;
  logic [PAGE_W-1:0]              offs;
  logic [CNT_W-1:0]               cnt;
  logic [7:0]                     status;
  logic                           commit;

  assign status  = {4'b0000, BP_INIT, wel, wip};
  assign tx_byte = (state == ST_STATUS) ? status : rd_data;
  assign commit  = sel_end && sel_aligned && (state == ST_WDATA) && (|wr_mask) && !wip;
  assign wr_en   = wip && (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      offs    <= '0;
      cnt     <= '0;
      wip     <= 1'b0;
      wel     <= 1'b0;
      rd_addr <= '0;
      wr_page <= '0;
      wr_mask <= '0;
      wr_data <= '0;
    end else begin
      if (sel_start) begin
        state <= ST_OPCODE;
      end else if (sel_end) begin
        state <= ST_IDLE;
        if (commit) begin
          wip <= 1'b1;
          cnt <= '0;
        end else if (!wip) begin
          wr_mask <= '0;
        end
      end else if (rx_valid) begin
        case (state)
          ST_OPCODE: begin
            if (wip) begin
              state <= (rx_byte == OP_RDSR) ? ST_STATUS : ST_IGNORE;
            end else begin
              case (rx_byte)
                OP_WREN: begin
                  wel   <= 1'b1;
                  state <= ST_IGNORE;
                end
                OP_WRITE: state <= wel ? ST_WADDR : ST_IGNORE;
                OP_READ:  state <= ST_RADDR;
                OP_RDSR:  state <= ST_STATUS;
                default:  state <= ST_IGNORE;
              endcase
            end
          end
          ST_WADDR: begin
            wr_page <= rx_byte[ADDR_W-1:PAGE_W];
            offs    <= rx_byte[PAGE_W-1:0];
            wr_mask <= '0;
            state   <= ST_WDATA;
          end
          ST_WDATA: begin
            wr_data[offs] <= rx_byte;
            wr_mask[offs] <= 1'b1;
            offs          <= offs + 1'b1;
          end
          ST_RADDR: begin
            rd_addr <= rx_byte[ADDR_W-1:0];
            state   <= ST_RDATA;
          end
          ST_RDATA: rd_addr <= rd_addr + 1'b1;
          default: ;
        endcase
      end

      // self-timed programming cycle
      if (wip && !commit) begin
        if (cnt == CNT_LAST) begin
          wip     <= 1'b0;
          wel     <= 1'b0;
          wr_mask <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  initial begin
    if (PAGE_W >= ADDR_W || ADDR_W > 8 || PAGE_BYTES < 2)
      $display("spi_eeprom_cmd: unsupported geometry");
  end
endmodule

// File: rtl/spi_eeprom_wctl.sv
module spi_eeprom_wctl #(
  parameter int         ADDR_W      = 8,
  parameter int         PAGE_W      = 4,
  parameter int         PROG_CYCLES = 1200,
  parameter logic [1:0] BP_INIT     = 2'b10,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic                          rx_valid;
  logic [7:0]                    rx_byte;
  logic                          sel_start, sel_end, sel_aligned;
  logic [7:0]                    tx_byte;
  logic [7:0]                    rd_data;
  logic [ADDR_W-1:0]             rd_addr;
  logic                          wr_en;
  logic [ADDR_W-PAGE_W-1:0]      wr_page;
  logic [PAGE_BYTES-1:0]         wr_mask;
  logic [PAGE_BYTES-1:0][7:0]    wr_data;
  logic                          wip, wel;
  logic                          commit_ok;

  assign commit_ok = sel_end & sel_aligned;

  spi_eeprom_frontend #(.SYNC_STAGES(SYNC_STAGES)) fe_i (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .tx_byte(tx_byte), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .sel_start(sel_start), .sel_end(sel_end), .sel_aligned(sel_aligned),
    .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  spi_eeprom_cmd #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PROG_CYCLES(PROG_CYCLES), .BP_INIT(BP_INIT)
  ) cmd_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .sel_start(sel_start), .sel_end(sel_end), .sel_aligned(sel_aligned),
    .rd_data(rd_data), .tx_byte(tx_byte), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_page(wr_page), .wr_mask(wr_mask), .wr_data(wr_data),
    .wip(wip), .wel(wel)
  );

  spi_eeprom_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) arr_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_page(wr_page),
    .wr_mask(wr_mask), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/spi_eeprom_wctl_chk.sv
module spi_eeprom_wctl_chk #(
  parameter int PROG_CYCLES = 1200
) (
  input logic clk,
  input logic rst_n,
  input logic spi_cs_n,
  input logic spi_miso_oe,
  input logic wip,
  input logic wel,
  input logic wr_en,
  input logic commit_ok
);
  logic [31:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else        run <= wip ? run + 32'd1 : 32'd0;
  end

  // R8: programming lasts exactly PROG_CYCLES clocks
  p_wip_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> (run == 32'(PROG_CYCLES)));

  // R8: latch is clear once programming finishes
  p_wel_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel);

  // R3: programming only starts with the latch armed
  p_need_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(wel));

  // R4: programming only starts on an aligned deselect
  p_aligned_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(commit_ok));

  // R7: the array is written once, as programming ends
  p_write_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wip);

  // R1: output floats while deselected
  p_oe_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso_oe);
endmodule

bind spi_eeprom_wctl spi_eeprom_wctl_chk #(.PROG_CYCLES(PROG_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso_oe(spi_miso_oe),
  .wip(wip), .wel(wel), .wr_en(wr_en), .commit_ok(commit_ok)
);

// File: tb/spi_eeprom_wctl_tb_top.sv
module spi_eeprom_wctl_tb_top;
  localparam int         PROG = 1200;
  localparam logic [1:0] BP   = 2'b10;
  localparam int         H    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe;

  always #2 clk = ~clk;

  spi_eeprom_wctl #(.PROG_CYCLES(PROG), .BP_INIT(BP)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] mem_m [256];
  bit wel_m = 0;
  logic [7:0] dat [32];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] status_m(input bit wip);
    return {4'b0000, BP, wel_m, wip};
  endfunction

  task automatic sel();
    @(negedge clk); spi_cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic desel();
    repeat (H) @(negedge clk); spi_cs_n = 1'b1;
    repeat (2*H) @(negedge clk);
  endtask

  task automatic bits(input logic [7:0] v, input int n, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - n; i--) begin
      spi_mosi = v[i];
      repeat (H) @(negedge clk);
      r = {r[6:0], spi_miso};
      spi_sck = 1'b1;
      repeat (H) @(negedge clk);
      spi_sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] v, output logic [7:0] r);
    bits(v, 8, r);
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    sel(); xfer(8'h05, d); xfer(8'h00, s); desel();
  endtask

  task automatic wren();
    logic [7:0] d;
    sel(); xfer(8'h06, d); desel();
    wel_m = 1;
  endtask

  // sends a write; cut>0 adds a partial byte of cut bits before deselect
  task automatic wr(input logic [7:0] a, input int n, input int cut);
    logic [7:0] d;
    sel(); xfer(8'h02, d); xfer(a, d);
    for (int i = 0; i < n; i++) xfer(dat[i], d);
    if (cut > 0) bits(8'hA5, cut, d);
    desel();
  endtask

  function automatic void model_write(input logic [7:0] a, input int n);
    for (int i = 0; i < n; i++) mem_m[{a[7:4], 4'(a[3:0] + i)}] = dat[i];
  endfunction

  task automatic wait_idle(input string req);
    logic [7:0] s;
    int k = 0;
    rdsr(s);
    while (s[0] && k < 40) begin rdsr(s); k++; end
    chk(req, {24'h0, s}, {24'h0, status_m(1'b0)});
  endtask

  task automatic read_chk(input logic [7:0] a, input int n, input string req);
    logic [7:0] d;
    sel(); xfer(8'h03, d); xfer(a, d);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, d);
      chk(req, {24'h0, d}, {24'h0, mem_m[8'(a + i)]});
    end
    desel();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, d;
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 oe", {31'h0, spi_miso_oe}, 32'h0);
    rdsr(s);
    chk("R1 status", {24'h0, s}, {24'h0, status_m(1'b0)});

    // R2 write enable
    wren();
    rdsr(s);
    chk("R2 wel set", {24'h0, s}, {24'h0, status_m(1'b0)});

    // R8 R9 directed programming with status polled during the cycle
    for (int i = 0; i < 3; i++) dat[i] = 8'h30 + 8'(i);
    wr(8'h42, 3, 0);
    rdsr(s);
    chk("R9 status during wip", {24'h0, s}, {24'h0, status_m(1'b1)});
    dat[0] = 8'hEE;
    begin
      logic [7:0] dd;
      sel(); xfer(8'h02, dd); xfer(8'h50, dd); xfer(8'hEE, dd); desel();
      sel(); xfer(8'h06, dd); desel();
    end
    for (int i = 0; i < 3; i++) dat[i] = 8'h30 + 8'(i);
    model_write(8'h42, 3);
    wel_m = 0;
    wait_idle("R8 wip and wel clear");
    read_chk(8'h40, 16, "R7 page after write");
    read_chk(8'h50, 2, "R9 write during wip ignored");

    // R10 read across top of array
    mem_m[8'hFF] = 8'h00;
    wren();
    dat[0] = 8'h9C; dat[1] = 8'h9D;
    wr(8'hFF, 2, 0);
    model_write(8'hFF, 2);
    wel_m = 0;
    wait_idle("R8 after wrap write");
    read_chk(8'hFE, 4, "R10 read wraps address");

    // random mixture
    for (int it = 0; it < 12; it++) begin
      int kind = $urandom % 5;
      logic [7:0] a = 8'($urandom);
      int n = 1 + ($urandom % 8);
      for (int i = 0; i < 32; i++) dat[i] = 8'($urandom);
      case (kind)
        0: begin
          wren(); wr(a, n, 0); model_write(a, n); wel_m = 0;
          wait_idle("R7 random write");
        end
        1: begin
          wr(a, n, 0);
          if (wel_m) begin model_write(a, n); wel_m = 0; wait_idle("R8 random write"); end
          else begin rdsr(s); chk("R3 write without wel", {24'h0, s}, {24'h0, status_m(1'b0)}); end
        end
        2: begin
          wren(); wr(a, n, 1 + ($urandom % 7));
          rdsr(s); chk("R4 cancel mid byte", {24'h0, s}, {24'h0, status_m(1'b0)});
        end
        3: begin
          wren(); wr(a, 0, 0);
          rdsr(s); chk("R5 address only", {24'h0, s}, {24'h0, status_m(1'b0)});
        end
        default: begin
          n = 17 + ($urandom % 8);
          wren(); wr(a, n, 0); model_write(a, n); wel_m = 0;
          wait_idle("R6 wrapping write");
        end
      endcase
      read_chk({a[7:4], 4'h0}, 16, "R6 R7 page contents");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule